// File: doc/BRIEF.md
# Packet Header Selection Filter

This block decides, for every packet header it is shown, whether the packet should be kept. It holds two small lists that software programs ahead of time. One list holds data type codes and the other holds virtual channel numbers, and every entry has its own enable bit. Each list also has a polarity bit. With the polarity bit clear, the list works as a blocklist and a match drops the packet. With the polarity bit set, the list works as an allowlist and only matching packets get through.

A packet is kept only when it passes both the data type test and the virtual channel test. The header arrives as a one-cycle strobe that carries a 6-bit data type and a virtual channel number. One clock edge later the block presents a registered keep flag together with its own valid strobe. The stage that sits downstream of the header parser uses that flag to gate payload capture.

Top module: `hdr_sel_filter`

## Requirements
- R1: After a synchronous reset, `res_vld` and `res_keep` are both 0.
- R2: Every cycle where `hdr_vld` is 1 is followed in the next cycle by `res_vld` = 1. `res_vld` is 0 in the cycle after a cycle where `hdr_vld` is 0.
- R3: With `dt_allow` = 0, the data type test fails when `hdr_dt` equals `dt_code[i]` of any entry i whose bit i in `dt_en` is 1. The test passes otherwise.
- R4: With `dt_allow` = 1, the data type test passes only when `hdr_dt` equals the code of an enabled entry.
- R5: With `vc_allow` = 0, the virtual channel test fails when `hdr_vc` equals `vc_num[i]` of an enabled entry. The test passes otherwise.
- R6: With `vc_allow` = 1, the virtual channel test passes only when `hdr_vc` equals an enabled entry.
- R7: `res_keep` is 1 only when both tests pass.
- R8: An entry whose enable bit is 0 never matches, whatever its value. With all enables 0, a blocklist passes every packet and an allowlist passes none.
- R9: When `res_vld` is 0, `res_keep` is 0. The list and polarity values are sampled in the same cycle as the header.

Entry i occupies bits [6i+5:6i] of `dt_code` and bits [VCW*i+VCW-1:VCW*i] of `vc_num`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hdr_vld | input | 1 | Header strobe |
| hdr_dt | input | 6 | Data type of the header |
| hdr_vc | input | VCW (4) | Virtual channel of the header |
| dt_code | input | 6*N (48) | Packed data type list entries |
| dt_en | input | N (8) | Data type entry enables |
| dt_allow | input | 1 | 1 = data type list is an allowlist |
| vc_num | input | VCW*N (32) | Packed virtual channel list entries |
| vc_en | input | N (8) | Virtual channel entry enables |
| vc_allow | input | 1 | 1 = virtual channel list is an allowlist |
| res_vld | output | 1 | Result valid, one cycle after `hdr_vld` |
| res_keep | output | 1 | Keep decision for that header |

## Verification
Both results fall due exactly one cycle after their header: `res_vld` and `res_keep` come out of a single register stage. The bench drives each header just after a falling edge, lets one rising edge pass, and then samples the outputs at the following falling edge. It compares them with a model in the bench that was computed from the inputs it applied. Idle cycles are interleaved so that the bench can also check that a quiet input produces a quiet output in the next cycle.

// File: rtl/hdr_sel_pkg.sv
package hdr_sel_pkg;
  localparam int DT_W = 6;
  typedef enum logic { LIST_BLOCK = 1'b0, LIST_ALLOW = 1'b1 } list_mode_e;
endpackage

// File: rtl/list_match.sv
module list_match #(
  parameter int N = 8,
  parameter int W = 6
) (
  input  logic [W-1:0]   key,
  input  logic [W*N-1:0] entries,
  input  logic [N-1:0]   en,
  input  logic           allow,
  output logic           pass
);
  import hdr_sel_pkg::*;
  logic [N-1:0] hit;
  for (genvar i = 0; i < N; i++) begin : g_ent
    assign hit[i] = en[i] && (entries[W*i +: W] == key);
  end
  always_comb begin
    if (list_mode_e'(allow) == LIST_ALLOW) pass = |hit;
    else                                   pass = ~|hit;
  end
endmodule

// File: rtl/hdr_sel_filter.sv
module hdr_sel_filter #(
  parameter int N   = 8,
  parameter int VCW = 4
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             hdr_vld,
  input  logic [hdr_sel_pkg::DT_W-1:0]     hdr_dt,
  input  logic [VCW-1:0]                   hdr_vc,
  input  logic [hdr_sel_pkg::DT_W*N-1:0]   dt_code,
  input  logic [N-1:0]                     dt_en,
  input  logic                             dt_allow,
  input  logic [VCW*N-1:0]                 vc_num,
  input  logic [N-1:0]                     vc_en,
  input  logic                             vc_allow,
  output logic                             res_vld,
  output logic                             res_keep
);
  import hdr_sel_pkg::*;
  logic dt_pass, vc_pass;

  list_match #(.N(N), .W(DT_W)) u_dt (
    .key(hdr_dt), .entries(dt_code), .en(dt_en), .allow(dt_allow), .pass(dt_pass)
  );
  list_match #(.N(N), .W(VCW)) u_vc (
    .key(hdr_vc), .entries(vc_num), .en(vc_en), .allow(vc_allow), .pass(vc_pass)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_vld  <= 1'b0;
      res_keep <= 1'b0;
    end else begin
      res_vld  <= hdr_vld;
      res_keep <= hdr_vld && dt_pass && vc_pass;
    end
  end
endmodule

// File: rtl/hdr_sel_filter_chk.sv
module hdr_sel_filter_chk #(
  parameter int N   = 8,
  parameter int VCW = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           hdr_vld,
  input logic [N-1:0]   dt_en,
  input logic           dt_allow,
  input logic [N-1:0]   vc_en,
  input logic           vc_allow,
  input logic           res_vld,
  input logic           res_keep
);
  p_vld_follows_r2: assert property (@(posedge clk) disable iff (rst)
    hdr_vld |=> res_vld);
  p_idle_follows_r2: assert property (@(posedge clk) disable iff (rst)
    !hdr_vld |=> !res_vld);
  p_keep_needs_vld_r9: assert property (@(posedge clk) disable iff (rst)
    res_keep |-> res_vld);
  p_empty_allow_dt_r8: assert property (@(posedge clk) disable iff (rst)
    (hdr_vld && dt_allow && dt_en == '0) |=> !res_keep);
  p_empty_allow_vc_r8: assert property (@(posedge clk) disable iff (rst)
    (hdr_vld && vc_allow && vc_en == '0) |=> !res_keep);
  p_empty_block_r7: assert property (@(posedge clk) disable iff (rst)
    (hdr_vld && !dt_allow && !vc_allow && dt_en == '0 && vc_en == '0) |=> res_keep);
  p_reset_r1: assert property (@(posedge clk)
    $past(rst) |-> (!res_vld && !res_keep));
endmodule

bind hdr_sel_filter hdr_sel_filter_chk #(.N(N), .VCW(VCW)) u_chk (
  .clk(clk), .rst(rst), .hdr_vld(hdr_vld), .dt_en(dt_en), .dt_allow(dt_allow),
  .vc_en(vc_en), .vc_allow(vc_allow), .res_vld(res_vld), .res_keep(res_keep)
);

// File: tb/hdr_sel_filter_tb.sv
module hdr_sel_filter_tb;
  localparam int N = 8;
  localparam int VCW = 4;

  logic clk = 0, rst = 1;
  logic hdr_vld = 0;
  logic [5:0] hdr_dt = 0;
  logic [VCW-1:0] hdr_vc = 0;
  logic [6*N-1:0] dt_code = 0;
  logic [N-1:0] dt_en = 0, vc_en = 0;
  logic dt_allow = 0, vc_allow = 0;
  logic [VCW*N-1:0] vc_num = 0;
  logic res_vld, res_keep;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  hdr_sel_filter #(.N(N), .VCW(VCW)) u_dut (.*);

  function automatic bit dt_ok(logic [5:0] d);
    bit hit = 0;
    for (int i = 0; i < N; i++) if (dt_en[i] && dt_code[6*i +: 6] == d) hit = 1;
    return dt_allow ? hit : !hit;
  endfunction

  function automatic bit vc_ok(logic [VCW-1:0] v);
    bit hit = 0;
    for (int i = 0; i < N; i++) if (vc_en[i] && vc_num[VCW*i +: VCW] == v) hit = 1;
    return vc_allow ? hit : !hit;
  endfunction

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic send(string req, logic [5:0] d, logic [VCW-1:0] v);
    bit e;
    @(negedge clk);
    hdr_vld = 1; hdr_dt = d; hdr_vc = v;
    e = dt_ok(d) && vc_ok(v);
    @(negedge clk);
    hdr_vld = 0;
    chk({req, " vld"}, res_vld, 1'b1);
    chk(req, res_keep, e);
  endtask

  task automatic idle;
    @(negedge clk);
    hdr_vld = 0;
    @(negedge clk);
    chk("R2 idle vld", res_vld, 1'b0);
    chk("R9 idle keep", res_keep, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    chk("R1 reset vld", res_vld, 1'b0);
    chk("R1 reset keep", res_keep, 1'b0);
    rst = 0;
    // R8: empty blocklists keep everything
    send("R8 empty block", 6'h2B, 4'd3);
    // R8: empty allowlist keeps nothing
    dt_allow = 1; send("R8 empty dt allow", 6'h2B, 4'd3);
    dt_allow = 0; vc_allow = 1; send("R8 empty vc allow", 6'h2B, 4'd3);
    vc_allow = 0;
    // R3 blocklist match
    dt_code[6*2 +: 6] = 6'h2C; dt_en[2] = 1;
    send("R3 dt block hit", 6'h2C, 4'd0);
    send("R3 dt block miss", 6'h2D, 4'd0);
    // R8 disabled entry ignored
    dt_code[6*5 +: 6] = 6'h12;
    send("R8 disabled dt entry", 6'h12, 4'd0);
    // R4 allowlist
    dt_allow = 1;
    send("R4 dt allow hit", 6'h2C, 4'd0);
    send("R4 dt allow miss", 6'h2D, 4'd0);
    // R5/R6 vc lists
    dt_allow = 0; dt_en = 0;
    vc_num[VCW*7 +: VCW] = 4'd9; vc_en[7] = 1;
    send("R5 vc block hit", 6'h1E, 4'd9);
    send("R5 vc block miss", 6'h1E, 4'd8);
    vc_allow = 1;
    send("R6 vc allow hit", 6'h1E, 4'd9);
    send("R6 vc allow miss", 6'h1E, 4'd8);
    // R7 both must pass
    dt_en[2] = 1;
    send("R7 dt fail vc pass", 6'h2C, 4'd9);
    send("R7 both pass", 6'h2D, 4'd9);
    idle();
    // random mix
    for (int k = 0; k < 400; k++) begin
      dt_code = {$urandom, $urandom};
      vc_num = $urandom;
      dt_en = $urandom; vc_en = $urandom;
      dt_allow = $urandom; vc_allow = $urandom;
      if (k % 3 == 0)
        send("R7 random", dt_code[6*(k%N) +: 6], vc_num[VCW*((k/3)%N) +: VCW]);
      else
        send("R7 random", 6'($urandom), VCW'($urandom));
      if (k % 7 == 0) idle();
    end
    // R1 reset mid-stream
    @(negedge clk); hdr_vld = 1; rst = 1;
    @(negedge clk); hdr_vld = 0;
    chk("R1 reset vld mid", res_vld, 1'b0);
    rst = 0;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule